// File: doc/BRIEF.md
# Scan Self-Test Delay-Test Sequencer

This block runs a transition-delay self-test on a circuit that has one internal scan chain. It uses a test-per-scan scheme. The chain is loaded serially from a pseudo-random stream, a vector pair is applied, and the response is captured. The next load then pushes the old chain contents out while it loads the new pattern. The block generates every test stimulus itself. A Galois LFSR supplies the primary-input word for each pattern, and a second LFSR supplies the serial scan-in bit. A third LFSR works as the shift-length counter: a shift phase ends when this LFSR reaches a fixed terminal state. There is no binary counter for this job.

Each pattern uses one of two launch schemes, chosen at start. In launch-on-shift, the final shift clock launches the transition, and one functional clock with scan enable low captures it. In launch-on-capture, the chain is loaded and scan enable drops. One functional clock then launches the transition and a second functional clock captures it. All scan-out bits and primary outputs seen during shifting, and the primary outputs seen at each capture, feed a multiple-input signature register. After the last pattern, one extra unload pass empties the chain into the signature. The signature is then compared with a good-circuit value that is supplied as an input.

All pins are plain control and status levels. No stream crosses the boundary, so no handshake or back-pressure exists. The circuit under test advances only in cycles where `cut_clk_en` is high.

Top module: `scan_bist_seq`

## Requirements
- R1: After reset, `scan_en`, `cut_clk_en`, `done` and `fail` are 0. A `start` pulse accepted in the idle or finished state reseeds all three LFSRs. The same pulse clears the signature, so `signature` reads 0 on the following cycle.
- R2: Every shift phase lasts exactly CHAIN_LEN cycles, with `scan_en`=1 and `cut_clk_en`=1. The phase ends when the counter LFSR (seed 1, polynomial mask 4'h9) reaches its terminal state. No shifting happens outside shift phases.
- R3: With `los_mode`=1 sampled at start, each load is followed by exactly one cycle with `cut_clk_en`=1 and `scan_en`=0 (the capture). One idle cycle follows, with `cut_clk_en`=0.
- R4: With `los_mode`=0 sampled at start, each load is followed by exactly two cycles with `cut_clk_en`=1 and `scan_en`=0 (launch, then capture). One idle cycle follows.
- R5: `cut_pi` holds a Galois LFSR word with seed 4'h5 and mask 4'h9. The next state is the word shifted left by one bit, with the mask XORed in when the outgoing MSB is 1. The word advances exactly once per pattern, and only in the idle cycle when `cut_clk_en`=0. `cut_si` is the MSB of a 5-bit Galois LFSR (seed 5'h13, mask 5'h09), which advances on every shift cycle.
- R6: The block applies max(`pat_count`,1) patterns. One extra CHAIN_LEN-cycle unload pass follows, and then `done` rises. From start to `done` the run takes P*(CHAIN_LEN+2)+CHAIN_LEN+1 clock edges in launch-on-shift and P*(CHAIN_LEN+3)+CHAIN_LEN+1 in launch-on-capture.
- R7: The signature register is an 8-bit Galois register with mask 8'h1D. On every shift cycle and every capture cycle it takes its own advanced value XOR {3'b0, `cut_po`, `cut_so`}. Every other cycle leaves it unchanged.
- R8: `done` stays high until the next accepted start. While `done` is high, `fail` equals (`signature` != `golden_sig`). A `start` pulse during a run has no effect on timing or signature.
- R9: No LFSR ever holds the all-zero state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a test run (accepted when idle or done) |
| los_mode | input | 1 | 1 = launch-on-shift, 0 = launch-on-capture; sampled at start |
| pat_count | input | PAT_W | Number of patterns; sampled at start, 0 acts as 1 |
| golden_sig | input | SIG_W | Expected good-circuit signature |
| cut_po | input | PO_W | Primary outputs of the circuit under test |
| cut_so | input | 1 | Scan-out bit of the chain |
| cut_pi | output | PI_W | Primary-input pattern word |
| cut_si | output | 1 | Serial scan-in bit |
| scan_en | output | 1 | Chain shifts when high, captures when low |
| cut_clk_en | output | 1 | Circuit clock enable |
| signature | output | SIG_W | Current signature register |
| done | output | 1 | Run finished |
| fail | output | 1 | Signature mismatch, valid with done |

## Verification
Two events share one cycle every pattern. The unload of the previous response is compacted in the same cycles that load the new pattern. In launch-on-shift, the counter LFSR hits its terminal state in the same cycle that the final shift launches the transition. Runs of several pattern counts in both modes provoke these overlaps. The bench judges the result against a software model built from the requirements: it checks the final signature, the exact count of shift and functional-clock cycles, and the latency to done. A start pulse injected mid-shift checks that the overlap is not disturbed.

// File: rtl/sbist_pkg.sv
package sbist_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_SHIFT   = 3'd1,
    ST_LAUNCH  = 3'd2,
    ST_CAPTURE = 3'd3,
    ST_NEXT    = 3'd4,
    ST_DONE    = 3'd5
  } seq_state_e;

  // one Galois step on a w-bit value held in 32 bits
  function automatic logic [31:0] gal_adv(input int w, input logic [31:0] poly,
                                          input logic [31:0] s);
    logic [31:0] m;
    logic [31:0] r;
    m = (32'h1 << w) - 32'h1;
    r = (s << 1) & m;
    if (s[w-1]) r = r ^ (poly & m);
    return r;
  endfunction

  function automatic logic [31:0] gal_walk(input int w, input logic [31:0] poly,
                                           input logic [31:0] seed, input int n);
    logic [31:0] s;
    s = seed;
    for (int i = 0; i < n; i++) s = gal_adv(w, poly, s);
    return s;
  endfunction

endpackage

// File: rtl/sbist_lfsr.sv
module sbist_lfsr
  import sbist_pkg::*;
#(
  parameter int unsigned W    = 4,
  parameter logic [W-1:0] POLY = W'(9),
  parameter logic [W-1:0] SEED = W'(1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= SEED;
    else if (load) q <= SEED;
    else if (step) q <= W'(gal_adv(W, 32'(POLY), 32'(q)));
  end

  // R9: a seeded XOR-feedback register never falls into the all-zero lock
  a_r9_never_zero: assert property (@(posedge clk) disable iff (!rst_n) q != '0);

endmodule

// File: rtl/sbist_misr.sv
module sbist_misr
  import sbist_pkg::*;
#(
  parameter int unsigned W    = 8,
  parameter int unsigned DW   = 5,
  parameter logic [W-1:0] POLY = W'(8'h1D)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          en,
  input  logic [DW-1:0] din,
  output logic [W-1:0]  sig
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sig <= '0;
    else if (clear) sig <= '0;
    else if (en)    sig <= W'(gal_adv(W, 32'(POLY), 32'(sig))) ^ W'(din);
  end

  // R1: a test start leaves an empty signature
  a_r1_clear_sig: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> sig == '0);
  // R7: no compaction means no change
  a_r7_hold_sig: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !en) |=> $stable(sig));

endmodule

// File: rtl/sbist_fsm.sv
module sbist_fsm
  import sbist_pkg::*;
#(
  parameter int unsigned CHAIN_LEN = 8,
  parameter int unsigned PAT_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             los_mode,
  input  logic [PAT_W-1:0] pat_count,
  input  logic             cnt_hit,
  output logic             seed_all,
  output logic             scan_en,
  output logic             clk_en,
  output logic             scan_step,
  output logic             pi_step,
  output logic             cnt_step,
  output logic             cnt_load,
  output logic             misr_en,
  output logic             done
);

  localparam int unsigned RW = $clog2(CHAIN_LEN + 1);

  seq_state_e       st;
  logic             los_q, last_q;
  logic [PAT_W-1:0] npat_q, idx_q;
  logic             accept;

  assign accept    = start && (st == ST_IDLE || st == ST_DONE);
  assign seed_all  = accept;
  assign scan_en   = (st == ST_SHIFT);
  assign clk_en    = (st == ST_SHIFT) || (st == ST_LAUNCH) || (st == ST_CAPTURE);
  assign scan_step = (st == ST_SHIFT);
  assign cnt_step  = (st == ST_SHIFT) && !cnt_hit;
  assign cnt_load  = (st == ST_SHIFT) && cnt_hit;
  assign misr_en   = (st == ST_SHIFT) || (st == ST_CAPTURE);
  assign pi_step   = (st == ST_NEXT);
  assign done      = (st == ST_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      los_q  <= 1'b0;
      last_q <= 1'b0;
      npat_q <= '0;
      idx_q  <= '0;
    end else begin
      unique case (st)
        ST_IDLE, ST_DONE: if (accept) begin
          st     <= ST_SHIFT;
          los_q  <= los_mode;
          last_q <= 1'b0;
          idx_q  <= '0;
          npat_q <= (pat_count == '0) ? PAT_W'(1) : pat_count;
        end
        ST_SHIFT: if (cnt_hit) begin
          if (last_q)     st <= ST_DONE;
          else if (los_q) st <= ST_CAPTURE;
          else            st <= ST_LAUNCH;
        end
        ST_LAUNCH:  st <= ST_CAPTURE;
        ST_CAPTURE: st <= ST_NEXT;
        ST_NEXT: begin
          idx_q <= idx_q + PAT_W'(1);
          if (idx_q + PAT_W'(1) >= npat_q) last_q <= 1'b1;
          st <= ST_SHIFT;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // checker-side run-length counter for the shift window
  logic [RW-1:0] run_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              run_len <= '0;
    else if (st == ST_SHIFT) run_len <= run_len + RW'(1);
    else                     run_len <= '0;
  end

  // R2: the counter LFSR terminal state arrives on the CHAIN_LEN-th shift cycle
  a_r2_shift_len: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SHIFT && cnt_hit) |-> run_len == RW'(CHAIN_LEN - 1));
  // R3: launch-on-shift captures straight after the last shift
  a_r3_los_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_CAPTURE && los_q) |-> $past(st) == ST_SHIFT);
  // R4: launch-on-capture inserts one functional launch clock
  a_r4_loc_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_CAPTURE && !los_q) |-> $past(st) == ST_LAUNCH);
  // R8: a start pulse mid-shift does not disturb the run
  a_r8_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SHIFT && start && !cnt_hit) |=> st == ST_SHIFT);
  // R8: the finished state drives no clocks into the chain
  a_r8_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!scan_en && !clk_en));

endmodule

// File: rtl/scan_bist_seq.sv
module scan_bist_seq
  import sbist_pkg::*;
#(
  parameter int unsigned CHAIN_LEN = 8,
  parameter int unsigned PAT_W     = 8,
  parameter int unsigned PI_W      = 4,
  parameter int unsigned PO_W      = 4,
  parameter int unsigned SIG_W     = 8,
  parameter int unsigned SC_W      = 5,
  parameter int unsigned CNT_W     = 4,
  parameter logic [PI_W-1:0]  PI_POLY  = PI_W'(4'h9),
  parameter logic [PI_W-1:0]  PI_SEED  = PI_W'(4'h5),
  parameter logic [SC_W-1:0]  SC_POLY  = SC_W'(5'h09),
  parameter logic [SC_W-1:0]  SC_SEED  = SC_W'(5'h13),
  parameter logic [CNT_W-1:0] CNT_POLY = CNT_W'(4'h9),
  parameter logic [CNT_W-1:0] CNT_SEED = CNT_W'(4'h1),
  parameter logic [SIG_W-1:0] SIG_POLY = SIG_W'(8'h1D)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             los_mode,
  input  logic [PAT_W-1:0] pat_count,
  input  logic [SIG_W-1:0] golden_sig,
  input  logic [PO_W-1:0]  cut_po,
  input  logic             cut_so,
  output logic [PI_W-1:0]  cut_pi,
  output logic             cut_si,
  output logic             scan_en,
  output logic             cut_clk_en,
  output logic [SIG_W-1:0] signature,
  output logic             done,
  output logic             fail
);

  localparam int unsigned DW = PO_W + 1;
  localparam logic [CNT_W-1:0] CNT_TERM =
    CNT_W'(gal_walk(CNT_W, 32'(CNT_POLY), 32'(CNT_SEED), CHAIN_LEN - 1));

  logic             seed_all, scan_step, pi_step, cnt_step, cnt_load, misr_en;
  logic             cnt_hit;
  logic [SC_W-1:0]  sc_q;
  logic [CNT_W-1:0] cnt_q;

  sbist_fsm #(.CHAIN_LEN(CHAIN_LEN), .PAT_W(PAT_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .los_mode(los_mode),
    .pat_count(pat_count), .cnt_hit(cnt_hit), .seed_all(seed_all),
    .scan_en(scan_en), .clk_en(cut_clk_en), .scan_step(scan_step),
    .pi_step(pi_step), .cnt_step(cnt_step), .cnt_load(cnt_load),
    .misr_en(misr_en), .done(done)
  );

  sbist_lfsr #(.W(PI_W), .POLY(PI_POLY), .SEED(PI_SEED)) u_pi_gen (
    .clk(clk), .rst_n(rst_n), .load(seed_all), .step(pi_step), .q(cut_pi)
  );

  sbist_lfsr #(.W(SC_W), .POLY(SC_POLY), .SEED(SC_SEED)) u_si_gen (
    .clk(clk), .rst_n(rst_n), .load(seed_all), .step(scan_step), .q(sc_q)
  );

  sbist_lfsr #(.W(CNT_W), .POLY(CNT_POLY), .SEED(CNT_SEED)) u_len_ctr (
    .clk(clk), .rst_n(rst_n), .load(seed_all || cnt_load), .step(cnt_step), .q(cnt_q)
  );

  sbist_misr #(.W(SIG_W), .DW(DW), .POLY(SIG_POLY)) u_sig (
    .clk(clk), .rst_n(rst_n), .clear(seed_all), .en(misr_en),
    .din({cut_po, cut_so}), .sig(signature)
  );

  assign cnt_hit = (cnt_q == CNT_TERM);
  assign cut_si  = sc_q[SC_W-1];
  assign fail    = done && (signature != golden_sig);

  // R5: the input word moves only while the circuit clock is gated off
  a_r5_pi_gated: assert property (@(posedge clk) disable iff (!rst_n)
    cut_clk_en |=> $stable(cut_pi) || $past(seed_all));
  // R8: a finished run holds until restarted
  a_r8_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done && $stable(signature));

endmodule

// File: tb/test_scan_bist_seq.sv
`timescale 1ns/1ps
module test_scan_bist_seq;

  localparam int L = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       los_mode = 1'b0;
  logic [7:0] pat_count = 8'd0;
  logic [7:0] golden_sig = 8'd0;
  logic [3:0] cut_po;
  logic       cut_so;
  logic [3:0] cut_pi;
  logic       cut_si, scan_en, cut_clk_en, done, fail;
  logic [7:0] signature;
  logic [7:0] chain;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  scan_bist_seq i_scan_bist_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .los_mode(los_mode),
    .pat_count(pat_count), .golden_sig(golden_sig), .cut_po(cut_po),
    .cut_so(cut_so), .cut_pi(cut_pi), .cut_si(cut_si), .scan_en(scan_en),
    .cut_clk_en(cut_clk_en), .signature(signature), .done(done), .fail(fail)
  );

  // stand-in scan-wrapped circuit
  function automatic logic [7:0] f_next(input logic [7:0] c, input logic [3:0] p);
    logic [7:0] r;
    for (int i = 0; i < 8; i++)
      r[i] = c[(i+1)%8] ^ (c[(i+3)%8] & p[i%4]) ^ p[(i+1)%4];
    return r;
  endfunction

  function automatic logic [3:0] f_po(input logic [7:0] c, input logic [3:0] p);
    logic [3:0] r;
    for (int j = 0; j < 4; j++) r[j] = c[j] ^ c[j+4] ^ p[j];
    return r;
  endfunction

  assign cut_po = f_po(chain, cut_pi);
  assign cut_so = chain[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               chain <= 8'h00;
    else if (cut_clk_en)
      if (scan_en)            chain <= {chain[6:0], cut_si};
      else                    chain <= f_next(chain, cut_pi);
  end

  function automatic logic [7:0] gstep(input int w, input logic [7:0] poly, input logic [7:0] s);
    logic [7:0] m;
    logic [7:0] r;
    m = 8'((9'h1 << w) - 9'h1);
    r = (s << 1) & m;
    if (s[w-1]) r = r ^ poly;
    return r;
  endfunction

  // requirement-level model of a complete run
  function automatic logic [7:0] ref_sig(input int p, input bit los);
    logic [7:0] c = 8'h00, ms = 8'h00, pi = 8'h05, sc = 8'h13;
    for (int k = 0; k <= p; k++) begin
      for (int s = 0; s < L; s++) begin
        ms = gstep(8, 8'h1D, ms) ^ {3'b0, f_po(c, pi[3:0]), c[7]};
        c  = {c[6:0], sc[4]};
        sc = gstep(5, 8'h09, sc);
      end
      if (k < p) begin
        if (!los) c = f_next(c, pi[3:0]);
        ms = gstep(8, 8'h1D, ms) ^ {3'b0, f_po(c, pi[3:0]), c[7]};
        c  = f_next(c, pi[3:0]);
        pi = gstep(4, 8'h09, pi);
      end
    end
    return ms;
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; start = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // one complete run with port-level checks
  task automatic run(input int pc, input bit los, input bit bad_gold, input bit poke);
    int p, e, n, se, ce, pich, pibad, pizero;
    logic [7:0] exp_sig;
    logic [3:0] prev_pi;
    logic prev_ce;
    p = (pc == 0) ? 1 : pc;
    exp_sig = ref_sig(p, los);
    e = p * (L + (los ? 2 : 3)) + L + 1;
    do_reset();
    pat_count = 8'(pc); los_mode = los;
    golden_sig = bad_gold ? (exp_sig ^ 8'h01) : exp_sig;
    prev_pi = cut_pi; prev_ce = 1'b0;
    start = 1'b1;
    n = 0; se = 0; ce = 0; pich = 0; pibad = 0; pizero = 0;
    while (n < 5000) begin
      @(negedge clk);
      n++;
      if (n == 1) begin
        start = 1'b0;
        chk(signature == 8'h00, "R1", "signature cleared at start", signature, 0);
      end
      if (poke && n == 5) start = 1'b1;
      if (poke && n == 6) start = 1'b0;
      if (done) break;
      se += scan_en; ce += cut_clk_en;
      if (cut_pi == 4'h0) pizero++;
      if (cut_pi != prev_pi) begin
        pich++;
        if (prev_ce) pibad++;
      end
      prev_pi = cut_pi; prev_ce = cut_clk_en;
    end
    chk(n == e, "R6", "edges to done", n, e);
    chk(se == (p + 1) * L, "R2", "shift cycles", se, (p + 1) * L);
    chk(ce == (p + 1) * L + p * (los ? 1 : 2), los ? "R3" : "R4", "clock-enabled cycles",
        ce, (p + 1) * L + p * (los ? 1 : 2));
    chk(pich == p && pibad == 0, "R5", "pattern word steps", pich, p);
    chk(pizero == 0, "R9", "zero input word", pizero, 0);
    chk(signature == exp_sig, "R7", "final signature", signature, exp_sig);
    chk(fail == bad_gold, "R8", "fail flag", fail, bad_gold);
    repeat (4) @(negedge clk);
    chk(done == 1'b1 && signature == exp_sig, "R8", "done held", done, 1);
  endtask

  task automatic t_reset();
    do_reset();
    chk(!scan_en && !cut_clk_en && !done && !fail, "R1", "idle outputs",
        {scan_en, cut_clk_en, done, fail}, 0);
    chk(signature == 8'h00, "R1", "idle signature", signature, 0);
  endtask

  task automatic t_los();        run(3, 1'b1, 1'b0, 1'b0); endtask  // R3
  task automatic t_loc();        run(2, 1'b0, 1'b0, 1'b0); endtask  // R4
  task automatic t_zero_count(); run(0, 1'b1, 1'b0, 1'b0); endtask  // R6
  task automatic t_bad_golden(); run(1, 1'b0, 1'b1, 1'b0); endtask  // R8
  task automatic t_busy_start(); run(2, 1'b1, 1'b0, 1'b1); endtask  // R8
  task automatic t_long_loc();   run(20, 1'b0, 1'b0, 1'b0); endtask // R6

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_los();
    t_loc();
    t_zero_count();
    t_bad_golden();
    t_busy_start();
    t_long_loc();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule